// File: doc/BRIEF.md
# Master-Side Transaction Debug Agent

This agent sits on the request path between a master core and its network interface and runs on the core's own clock. It counts every transaction the core starts. It tracks how many of them are still waiting for a response. It also runs a free cycle timer. A programmable compare value, when enabled, turns a timer match into a local debug event. An incoming stop request on the shared line is also an event, but one that came from elsewhere.

When an event is taken, the agent latches a timestamped event snapshot and holds off new initiations. It then waits until all outstanding transactions have returned. After that it drops the core clock enable, latches a stop snapshot and raises its completion output. The agent stops at a transaction boundary, not at the breakpoint cycle. The two snapshots tell the debugger how far the core ran past the event. In step mode, initiation is held off all the time, and each incoming stop request lets exactly one transaction through before the same drain and stop sequence. A clear input, taken only while stopped, returns the agent to running.

Top module: `dbg_agent`

## Requirements
- R1: The transaction counter rises by exactly one in every cycle in which the core's request is accepted (coreReqValid and nocReqReady high while initiation is not blocked). It is visible through the snapshot registers.
- R2: The timer advances by one per cycle while the agent runs. It holds its value from the cycle the stop snapshot is taken until a clear. coreClkEn is low exactly while stopped.
- R3: In the cycle an event is taken, the timer and transaction count are latched into evTime/evCount, and these are visible from the next cycle.
- R4: evFlag is 1 when the event came from the local breakpoint and 0 when it came from stopReqIn. When both occur in the same cycle, the local flag wins.
- R5: A local breakpoint fires only when bpEnable is high and the timer equals bpValue. In the next cycle stopReqOut goes high, and it stays high until the clear.
- R6: From the event cycle itself until the clear, nocReqValid and coreReqReady are held low. The one exception is the single step transaction of R9.
- R7: The core is stopped only once the outstanding count is zero. The stop follows one cycle after the drain state observes zero outstanding.
- R8: On stopping, spTime/spCount take the frozen timer and the transaction count, spFlag is 0, and done goes high.
- R9: With stepMode high, initiation is blocked while running. A stop request lets exactly one transaction be accepted before draining, so spCount equals evCount plus one.
- R10: dbgClear while stopped returns the agent to running: done low, coreClkEn high, stopReqOut low, snapshots kept.
- R11: An accepted request and a response in the same cycle leave the outstanding count unchanged.
- R12: After reset, the snapshots are zero, done and stopReqOut are low, and coreClkEn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core functional clock |
| rstN | input | 1 | Active-low synchronous reset |
| coreReqValid | input | 1 | Core request valid |
| coreReqReady | output | 1 | Request ready back to the core, gated by blocking |
| nocReqValid | output | 1 | Request valid toward the network interface, gated by blocking |
| nocReqReady | input | 1 | Network interface request ready |
| rspValid | input | 1 | Response valid toward the core (monitored) |
| rspReady | input | 1 | Core response ready (monitored) |
| bpEnable | input | 1 | Breakpoint enable |
| bpValue | input | TIMER_W | Breakpoint compare value |
| stepMode | input | 1 | Single-transaction step mode |
| stopReqIn | input | 1 | Shared stop request from other agents |
| stopReqOut | output | 1 | Drives the shared stop request after a local event |
| dbgClear | input | 1 | Leave the stopped state |
| coreClkEn | output | 1 | Enable for the core clock gate |
| done | output | 1 | Core stopped after draining |
| evTime | output | TIMER_W | Event snapshot timer |
| evCount | output | CNT_W | Event snapshot transaction count |
| evFlag | output | 1 | Event snapshot origin flag |
| spTime | output | TIMER_W | Stop snapshot timer |
| spCount | output | CNT_W | Stop snapshot transaction count |
| spFlag | output | 1 | Stop snapshot flag, always 0 |

## Verification
The cycle-level assertions check several rules on every cycle. They check counter increments on acceptance, and the unchanged outstanding count for a same-cycle request and response. They check the frozen timer while stopped and the latching of the timer into the event snapshot. They also check the raising of the stop line after a local match, blocking during drain and stop, a zero outstanding count at the rising edge of done, and the single accepted step transaction. Some behaviour shows only over whole scenarios. That includes the exact event flag for each event origin, and a disabled breakpoint whose compare value is passed without effect. The same holds for the snapshot pair that shows how far a stepped core ran, and the return to running after a clear.

// File: rtl/dbg_agent_pkg.sv
package dbg_agent_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_STEP  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_HALT  = 2'd3
  } agentState_t;

  typedef struct packed {
    logic captureEv;
    logic evLocal;
    logic captureSp;
    logic timerRun;
  } agentStrobe_t;
endpackage

// File: rtl/dbg_agent_ctrl.sv
module dbg_agent_ctrl
  import dbg_agent_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         bpHit,
  input  logic         stopReqIn,
  input  logic         stepMode,
  input  logic         drained,
  input  logic         initFire,
  input  logic         dbgClear,
  output agentStrobe_t stb,
  output agentState_t  state,
  output logic         blockInit,
  output logic         stopReqOut,
  output logic         halted,
  output logic         coreClkEn
);
  agentState_t stateNext;
  logic localEv;
  logic anyEv;

  assign localEv = (state == ST_RUN) && bpHit;
  assign anyEv   = (state == ST_RUN) && (bpHit || stopReqIn);

  always_comb begin
    unique case (state)
      ST_RUN:  blockInit = stepMode || anyEv;
      ST_STEP: blockInit = 1'b0;
      default: blockInit = 1'b1;
    endcase
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN: begin
        if (anyEv) stateNext = (stepMode && !localEv) ? ST_STEP : ST_DRAIN;
      end
      ST_STEP: begin
        if (initFire) stateNext = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (drained) stateNext = ST_HALT;
      end
      ST_HALT: begin
        if (dbgClear) stateNext = ST_RUN;
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_comb begin
    stb.captureEv = anyEv;
    stb.evLocal   = localEv;
    stb.captureSp = (state == ST_DRAIN) && drained;
    stb.timerRun  = (state != ST_HALT) && !stb.captureSp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_RUN;
      stopReqOut <= 1'b0;
    end else begin
      state <= stateNext;
      if (localEv) stopReqOut <= 1'b1;
      else if (state == ST_HALT && dbgClear) stopReqOut <= 1'b0;
    end
  end

  assign halted    = (state == ST_HALT);
  assign coreClkEn = !halted;
endmodule

// File: rtl/dbg_agent_dp.sv
module dbg_agent_dp
  import dbg_agent_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int CNT_W   = 8,
  parameter int OUT_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  agentStrobe_t       stb,
  input  logic               initFire,
  input  logic               rspFire,
  input  logic               bpEnable,
  input  logic [TIMER_W-1:0] bpValue,
  output logic               bpHit,
  output logic               drained,
  output logic [TIMER_W-1:0] timerVal,
  output logic [CNT_W-1:0]   txCount,
  output logic [OUT_W-1:0]   outstanding,
  output logic [TIMER_W-1:0] evTime,
  output logic [CNT_W-1:0]   evCount,
  output logic               evFlag,
  output logic [TIMER_W-1:0] spTime,
  output logic [CNT_W-1:0]   spCount,
  output logic               spFlag
);
  localparam logic [OUT_W-1:0] OUT_ONE = OUT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [TIMER_W-1:0] TMR_ONE = TIMER_W'(1);

  assign bpHit   = bpEnable && (timerVal == bpValue);
  assign drained = (outstanding == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerVal    <= '0;
      txCount     <= '0;
      outstanding <= '0;
      evTime      <= '0;
      evCount     <= '0;
      evFlag      <= 1'b0;
      spTime      <= '0;
      spCount     <= '0;
      spFlag      <= 1'b0;
    end else begin
      if (stb.timerRun) timerVal <= timerVal + TMR_ONE;
      if (initFire) txCount <= txCount + CNT_ONE;
      unique case ({initFire, rspFire})
        2'b10:   outstanding <= outstanding + OUT_ONE;
        2'b01:   outstanding <= outstanding - OUT_ONE;
        default: outstanding <= outstanding;
      endcase
      if (stb.captureEv) begin
        evTime  <= timerVal;
        evCount <= txCount;
        evFlag  <= stb.evLocal;
      end
      if (stb.captureSp) begin
        spTime  <= timerVal;
        spCount <= txCount;
        spFlag  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbg_agent.sv
module dbg_agent
  import dbg_agent_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int CNT_W   = 8,
  parameter int OUT_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               coreReqValid,
  output logic               coreReqReady,
  output logic               nocReqValid,
  input  logic               nocReqReady,
  input  logic               rspValid,
  input  logic               rspReady,
  input  logic               bpEnable,
  input  logic [TIMER_W-1:0] bpValue,
  input  logic               stepMode,
  input  logic               stopReqIn,
  output logic               stopReqOut,
  input  logic               dbgClear,
  output logic               coreClkEn,
  output logic               done,
  output logic [TIMER_W-1:0] evTime,
  output logic [CNT_W-1:0]   evCount,
  output logic               evFlag,
  output logic [TIMER_W-1:0] spTime,
  output logic [CNT_W-1:0]   spCount,
  output logic               spFlag
);
  agentStrobe_t       stb;
  agentState_t        state;
  logic               blockInit;
  logic               initFire;
  logic               rspFire;
  logic               bpHit;
  logic               drained;
  logic [TIMER_W-1:0] timerVal;
  logic [CNT_W-1:0]   txCount;
  logic [OUT_W-1:0]   outstanding;

  assign coreReqReady = nocReqReady && !blockInit;
  assign nocReqValid  = coreReqValid && !blockInit;
  assign initFire     = coreReqValid && nocReqReady && !blockInit;
  assign rspFire      = rspValid && rspReady;

  dbg_agent_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .bpHit      (bpHit),
    .stopReqIn  (stopReqIn),
    .stepMode   (stepMode),
    .drained    (drained),
    .initFire   (initFire),
    .dbgClear   (dbgClear),
    .stb        (stb),
    .state      (state),
    .blockInit  (blockInit),
    .stopReqOut (stopReqOut),
    .halted     (done),
    .coreClkEn  (coreClkEn)
  );

  dbg_agent_dp #(
    .TIMER_W (TIMER_W),
    .CNT_W   (CNT_W),
    .OUT_W   (OUT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .initFire    (initFire),
    .rspFire     (rspFire),
    .bpEnable    (bpEnable),
    .bpValue     (bpValue),
    .bpHit       (bpHit),
    .drained     (drained),
    .timerVal    (timerVal),
    .txCount     (txCount),
    .outstanding (outstanding),
    .evTime      (evTime),
    .evCount     (evCount),
    .evFlag      (evFlag),
    .spTime      (spTime),
    .spCount     (spCount),
    .spFlag      (spFlag)
  );
endmodule

// File: rtl/dbg_agent_chk.sv
module dbg_agent_chk
  import dbg_agent_pkg::*;
#(
  parameter int TIMER_W = 16,
  parameter int CNT_W   = 8,
  parameter int OUT_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               initFire,
  input logic               rspFire,
  input logic [CNT_W-1:0]   txCount,
  input logic [OUT_W-1:0]   outstanding,
  input logic [TIMER_W-1:0] timerVal,
  input logic [TIMER_W-1:0] evTime,
  input logic               coreClkEn,
  input logic               done,
  input logic               coreReqReady,
  input logic               nocReqValid,
  input agentState_t        state,
  input agentStrobe_t       stb,
  input logic               stopReqOut,
  input logic               spFlag
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    initFire |=> txCount == $past(txCount) + CNT_W'(1));

  assert_timer_frozen_R2: assert property (@(posedge clk) disable iff (!rstN)
    !coreClkEn |=> $stable(timerVal));

  assert_event_time_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.captureEv |=> evTime == $past(timerVal));

  assert_local_stop_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    stb.evLocal |=> stopReqOut);

  assert_blocked_when_stopping_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DRAIN || state == ST_HALT) |-> (!coreReqReady && !nocReqValid));

  assert_stop_after_drain_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> outstanding == '0);

  assert_stop_flag_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !spFlag);

  assert_single_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STEP && initFire) |=> !coreReqReady);

  assert_pending_balance_R11: assert property (@(posedge clk) disable iff (!rstN)
    (initFire && rspFire) |=> $stable(outstanding));
endmodule

bind dbg_agent dbg_agent_chk #(
  .TIMER_W (TIMER_W),
  .CNT_W   (CNT_W),
  .OUT_W   (OUT_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .initFire     (initFire),
  .rspFire      (rspFire),
  .txCount      (txCount),
  .outstanding  (outstanding),
  .timerVal     (timerVal),
  .evTime       (evTime),
  .coreClkEn    (coreClkEn),
  .done         (done),
  .coreReqReady (coreReqReady),
  .nocReqValid  (nocReqValid),
  .state        (state),
  .stb          (stb),
  .stopReqOut   (stopReqOut),
  .spFlag       (spFlag)
);

// File: tb/dbg_agent_bench.sv
module dbg_agent_bench;
  localparam int TW = 16;
  localparam int CW = 8;
  localparam int OW = 4;
  localparam int TMOD = 1 << TW;
  localparam int CMOD = 1 << CW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic coreReqValid = 0, nocReqReady = 0, rspValid = 0, rspReady = 1;
  logic bpEnable = 0, stepMode = 0, stopReqIn = 0, dbgClear = 0;
  logic [TW-1:0] bpValue = '0;
  logic coreReqReady, nocReqValid, stopReqOut, coreClkEn, done, evFlag, spFlag;
  logic [TW-1:0] evTime, spTime;
  logic [CW-1:0] evCount, spCount;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model: 0 run, 1 step, 2 drain, 3 stopped
  int mState, mTimer, mCount, mOut, mEvT, mEvC, mEvF, mSpT, mSpC, mStop;

  always #10 clk = ~clk;

  dbg_agent u_dbg_agent (
    .clk(clk), .rstN(rstN),
    .coreReqValid(coreReqValid), .coreReqReady(coreReqReady),
    .nocReqValid(nocReqValid), .nocReqReady(nocReqReady),
    .rspValid(rspValid), .rspReady(rspReady),
    .bpEnable(bpEnable), .bpValue(bpValue), .stepMode(stepMode),
    .stopReqIn(stopReqIn), .stopReqOut(stopReqOut), .dbgClear(dbgClear),
    .coreClkEn(coreClkEn), .done(done),
    .evTime(evTime), .evCount(evCount), .evFlag(evFlag),
    .spTime(spTime), .spCount(spCount), .spFlag(spFlag)
  );

  function automatic bit mLocal();
    return mState == 0 && bpEnable && (mTimer == int'(bpValue));
  endfunction

  function automatic bit mEvent();
    return mState == 0 && (stopReqIn || (bpEnable && (mTimer == int'(bpValue))));
  endfunction

  function automatic bit mBlock();
    if (mState == 0) return stepMode || mEvent();
    if (mState == 1) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin : model
    bit ev, loc, fire, rsp, halting;
    if (!rstN) begin
      mState = 0; mTimer = 0; mCount = 0; mOut = 0;
      mEvT = 0; mEvC = 0; mEvF = 0; mSpT = 0; mSpC = 0; mStop = 0;
    end else begin
      ev = mEvent();
      loc = mLocal();
      fire = coreReqValid && nocReqReady && !mBlock();
      rsp = rspValid && rspReady;
      halting = (mState == 2) && (mOut == 0);
      if (ev) begin mEvT = mTimer; mEvC = mCount; mEvF = loc; end
      if (loc) mStop = 1;
      if (halting) begin mSpT = mTimer; mSpC = mCount; end
      if (mState != 3 && !halting) mTimer = (mTimer + 1) % TMOD;
      if (fire) mCount = (mCount + 1) % CMOD;
      mOut = mOut + int'(fire) - int'(rsp);
      case (mState)
        0: if (ev) mState = (stepMode && !loc) ? 1 : 2;
        1: if (fire) mState = 2;
        2: if (halting) mState = 3;
        default: if (dbgClear) begin mState = 0; mStop = 0; end
      endcase
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R6 coreReqReady", int'(coreReqReady), int'(nocReqReady && !mBlock()));
    chk("R6 nocReqValid", int'(nocReqValid), int'(coreReqValid && !mBlock()));
    chk("R5 stopReqOut", int'(stopReqOut), mStop);
    chk("R8 done", int'(done), int'(mState == 3));
    chk("R2 coreClkEn", int'(coreClkEn), int'(mState != 3));
    chk("R3 evTime", int'(evTime), mEvT);
    chk("R1 evCount", int'(evCount), mEvC);
    chk("R4 evFlag", int'(evFlag), mEvF);
    chk("R8 spTime", int'(spTime), mSpT);
    chk("R8 spCount", int'(spCount), mSpC);
    chk("R8 spFlag", int'(spFlag), 0);
  endtask

  task automatic cycle();
    #1 compareAll();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(bit cv, bit nr, bit rv);
    coreReqValid = cv;
    nocReqReady = nr;
    rspValid = rv && (mOut > 0);
    cycle();
  endtask

  task automatic clearStop();
    stopReqIn = 0;
    dbgClear = 1;
    drive(0, 1, 0);
    dbgClear = 0;
    drive(0, 1, 0);
    chk("R10 done after clear", int'(done), 0);
    chk("R10 stopReqOut after clear", int'(stopReqOut), 0);
    chk("R10 coreClkEn after clear", int'(coreClkEn), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int startCount;
    repeat (3) @(negedge clk);
    chk("R12 reset done", int'(done), 0);
    chk("R12 reset coreClkEn", int'(coreClkEn), 1);
    chk("R12 reset evTime", int'(evTime), 0);
    chk("R12 reset spCount", int'(spCount), 0);
    chk("R12 reset stopReqOut", int'(stopReqOut), 0);
    rstN = 1;
    drive(0, 1, 0);

    // normal initiations, R1 and R11
    repeat (3) drive(1, 1, 0);
    drive(1, 1, 1);          // R11: simultaneous request and response
    drive(0, 1, 1);
    drive(1, 0, 0);          // no handshake
    // incoming event with two pending
    stopReqIn = 1;
    drive(1, 1, 0);
    chk("R4 incoming flag", int'(evFlag), 0);
    chk("R1 event count", int'(evCount), 4);
    drive(1, 1, 1);
    chk("R7 still running with pending", int'(done), 0);
    drive(1, 1, 1);
    drive(1, 1, 0);
    drive(1, 1, 0);
    chk("R7 stopped after drain", int'(done), 1);
    chk("R8 stop count", int'(spCount), 4);
    repeat (3) drive(1, 1, 0);
    chk("R2 frozen stop time", int'(spTime), mTimer);
    clearStop();

    // disabled breakpoint passes without effect
    bpEnable = 0;
    bpValue = TW'(mTimer + 3);
    repeat (8) drive(0, 1, 0);
    chk("R5 disabled breakpoint", int'(stopReqOut), 0);
    chk("R5 disabled no stop", int'(done), 0);

    // local breakpoint with traffic
    bpEnable = 1;
    bpValue = TW'(mTimer + 5);
    repeat (4) drive(1, 1, 0);
    repeat (3) drive(1, 1, 1);
    repeat (6) drive(0, 1, 1);
    chk("R4 local flag", int'(evFlag), 1);
    chk("R3 event time", int'(evTime), int'(bpValue));
    chk("R5 stop line high", int'(stopReqOut), 1);
    chk("R7 local stop", int'(done), 1);
    bpEnable = 0;
    clearStop();

    // step mode: one transaction per stop request
    stepMode = 1;
    repeat (3) drive(1, 1, 0);
    chk("R9 blocked in step", int'(coreReqReady), 0);
    startCount = mCount;
    stopReqIn = 1;
    drive(1, 1, 0);
    drive(1, 1, 0);
    drive(1, 1, 0);
    repeat (5) drive(0, 1, 1);
    chk("R9 one step transaction", int'(spCount), startCount + 1);
    chk("R9 step event count", int'(evCount), startCount);
    chk("R9 stopped", int'(done), 1);
    clearStop();
    stepMode = 0;
    repeat (2) drive(0, 1, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule